// File: doc/BRIEF.md
# Two-Pin Bidirectional Port with Edge Interrupts

This block is a tiny general-purpose I/O port with two pins that sit on a 4-bit internal peripheral bus. Software stores output values in a data register at the port's primary address. It sets direction, interrupt enables, edge polarity and priority through a control byte at the matching auxiliary address. The control byte is loaded as two nibbles over the narrow bus. A read always returns the live level seen on the pins, so the bus can sample a pin in either direction.

Each pin can run as an output or as an input, chosen pin by pin. Outputs use either push-pull drive or an open-drain sink, picked by a strap. In open-drain mode a pin whose data bit is 1 releases the line, so an external device can drive it and the read path sees that level. Inputs get a weak pull-up or pull-down, chosen by a second strap. Each pin also feeds an edge detector behind a two-flop synchronizer. This detector raises a one-cycle interrupt request, together with a per-pin priority bit for a downstream interrupt controller.

Top module: `pio2_port`

## Requirements
- R1: A bus write with `bus_aux`=0 and `bus_addr`=6 hex stores `bus_wdata[1:0]` into the data register. Bits [3:2] are discarded, and a write to any other address changes nothing.
- R2: Control bit [i] (direction) at 0 makes pin i an output that drives data bit i (`pin_oe[i]`=1 in push-pull mode). A value of 1 makes it an input, and each pin is set independently.
- R3: With `strap_open_drain`=0 an output pin drives both levels. With `strap_open_drain`=1 an output pin sinks (`pin_oe`=1, `pin_out`=0) when its data bit is 0 and releases (`pin_oe`=0) when its data bit is 1, so an external level reaches the read path.
- R4: `bus_rdata` is always {2'b00, `pin_in`}, in every direction setting, and it never alters the configuration.
- R5: An input pin has its driver off (`pin_oe[i]`=0). The data register keeps its contents while the pin is an input and is shown again once the pin returns to output.
- R6: An input pin has `pin_pu_en[i]`=1 when `strap_pull_up`=1, or else `pin_pd_en[i]`=1. An output pin has both enables at 0.
- R7: The control byte goes through `bus_aux`=1 writes to address 6: low nibble first, then high nibble. Nothing takes effect until the high nibble arrives, and then all 8 bits update together. Layout: [1:0] direction, [3:2] interrupt enable, [5:4] edge select (1 = rising, 0 = falling), [7:6] priority.
- R8: When a pin's interrupt is enabled, a level change of the selected polarity on `pin_in[i]` gives `irq_req[i]`=1 for exactly one cycle, two clock edges after the change. Changes of the other polarity, or on a masked pin, give no request.
- R9: `irq_prio` reflects control bits [7:6].
- R10: After reset, both pins are inputs, interrupts are masked, edge select and priority are 0, the data register is 0 and the nibble sequence restarts at the low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_aux | input | 1 | 0 = primary (data) register, 1 = auxiliary (control) register |
| bus_addr | input | 4 | Bus address |
| bus_wdata | input | 4 | Bus write data |
| bus_rdata | output | 4 | Live pin levels, LSB aligned |
| strap_open_drain | input | 1 | 1 = open-drain outputs, 0 = push-pull |
| strap_pull_up | input | 1 | 1 = pull-up on inputs, 0 = pull-down |
| pin_in | input | 2 | Pad level seen from the pins |
| pin_out | output | 2 | Value driven when enabled |
| pin_oe | output | 2 | Driver enable per pin |
| pin_pu_en | output | 2 | Weak pull-up enable per pin |
| pin_pd_en | output | 2 | Weak pull-down enable per pin |
| irq_req | output | 2 | One-cycle interrupt request per pin |
| irq_prio | output | 2 | Priority bit per pin |

## Verification
Register writes become visible at the pad outputs one edge after the write cycle. A control byte counts from its high-nibble write only, and the low-nibble write alone must leave the pads unchanged one edge later. Read data and strap effects follow their inputs within the same cycle. An interrupt request is due on the second edge after a pin change and must be low again on the third. The bench stamps every expected item with the cycle in which it is due, and the monitor compares each item in exactly that cycle, away from the clock edge. An edge pushes separate zero items for the cycles before and after the pulse.

// File: rtl/pio2_pkg.sv
package pio2_pkg;
    localparam int PIN_W  = 2;
    localparam int BUS_W  = 4;
    localparam int ADDR_W = 4;
    localparam int SYNC_STAGES = 2;

    // control byte, MSB first
    typedef struct packed {
        logic [PIN_W-1:0] prio;
        logic [PIN_W-1:0] rise;
        logic [PIN_W-1:0] irq_en;
        logic [PIN_W-1:0] dir;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    localparam ctl_t CTL_RST = '{prio: '0, rise: '0, irq_en: '0, dir: '1};

    typedef enum logic [1:0] {
        PAD_FLOAT = 2'd0,
        PAD_PUSH  = 2'd1,
        PAD_SINK  = 2'd2
    } pad_mode_e;

    function automatic pad_mode_e pad_mode(input logic is_input,
                                           input logic od,
                                           input logic dat);
        if (is_input)
            return PAD_FLOAT;
        else if (od && dat)
            return PAD_FLOAT;
        else if (od)
            return PAD_SINK;
        else
            return PAD_PUSH;
    endfunction
endpackage

// File: rtl/pio2_regs.sv
module pio2_regs
    import pio2_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 4'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_aux,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  data_q,
    output ctl_t              ctl_q,
    output logic              phase_q
);
    localparam int HALF_W = CTL_W / 2;

    logic              hit;
    logic [HALF_W-1:0] stage_q;

    assign hit = bus_we && (bus_addr == PORT_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            ctl_q   <= CTL_RST;
            stage_q <= '0;
            phase_q <= 1'b0;
        end else if (hit) begin
            if (!bus_aux) begin
                data_q <= bus_wdata[PIN_W-1:0];
            end else if (!phase_q) begin
                stage_q <= bus_wdata[HALF_W-1:0];
                phase_q <= 1'b1;
            end else begin
                ctl_q   <= ctl_t'({bus_wdata[HALF_W-1:0], stage_q});
                phase_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pio2_pad.sv
module pio2_pad
    import pio2_pkg::*;
(
    input  logic is_input,
    input  logic dat,
    input  logic od,
    input  logic pu_sel,
    output logic oe,
    output logic out,
    output logic pu,
    output logic pd
);
    pad_mode_e mode;

    always_comb begin
        mode = pad_mode(is_input, od, dat);
        oe   = 1'b0;
        out  = 1'b0;
        case (mode)
            PAD_PUSH: begin
                oe  = 1'b1;
                out = dat;
            end
            PAD_SINK: begin
                oe  = 1'b1;
                out = 1'b0;
            end
            default: begin
                oe  = 1'b0;
                out = 1'b0;
            end
        endcase
        pu = is_input &&  pu_sel;
        pd = is_input && !pu_sel;
    end
endmodule

// File: rtl/pio2_edge.sv
module pio2_edge
    import pio2_pkg::*;
#(
    parameter int N      = PIN_W,
    parameter int STAGES = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] en,
    input  logic [N-1:0] rise,
    output logic [N-1:0] irq
);
    logic [N-1:0] sync_q [STAGES];
    logic [N-1:0] prev_q;
    logic [N-1:0] now_lvl;

    assign now_lvl = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) sync_q[k] <= '0;
            prev_q <= '0;
        end else begin
            sync_q[0] <= pin;
            for (int k = 1; k < STAGES; k++) sync_q[k] <= sync_q[k-1];
            prev_q <= now_lvl;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_det
        logic up, down;
        assign up     =  now_lvl[i] && !prev_q[i];
        assign down   = !now_lvl[i] &&  prev_q[i];
        assign irq[i] = en[i] && (rise[i] ? up : down);
    end
endmodule

// File: rtl/pio2_port.sv
module pio2_port
    import pio2_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 4'h6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_aux,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              strap_open_drain,
    input  logic              strap_pull_up,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pin_pu_en,
    output logic [PIN_W-1:0]  pin_pd_en,
    output logic [PIN_W-1:0]  irq_req,
    output logic [PIN_W-1:0]  irq_prio
);
    logic [PIN_W-1:0] data_r;
    ctl_t             ctl_r;
    logic             phase_r;

    pio2_regs #(.PORT_ADDR(PORT_ADDR)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_aux   (bus_aux),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .data_q    (data_r),
        .ctl_q     (ctl_r),
        .phase_q   (phase_r)
    );

    for (genvar i = 0; i < PIN_W; i++) begin : g_pad
        pio2_pad u_pad (
            .is_input (ctl_r.dir[i]),
            .dat      (data_r[i]),
            .od       (strap_open_drain),
            .pu_sel   (strap_pull_up),
            .oe       (pin_oe[i]),
            .out      (pin_out[i]),
            .pu       (pin_pu_en[i]),
            .pd       (pin_pd_en[i])
        );
    end

    pio2_edge #(.N(PIN_W), .STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .pin  (pin_in),
        .en   (ctl_r.irq_en),
        .rise (ctl_r.rise),
        .irq  (irq_req)
    );

    assign irq_prio  = ctl_r.prio;
    assign bus_rdata = {{(BUS_W-PIN_W){1'b0}}, pin_in};
endmodule

// File: rtl/pio2_port_chk.sv
module pio2_port_chk
    import pio2_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_ADDR = 4'h6
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic              bus_aux,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              strap_open_drain,
    input logic [PIN_W-1:0]  pin_out,
    input logic [PIN_W-1:0]  pin_oe,
    input logic [PIN_W-1:0]  pin_pu_en,
    input logic [PIN_W-1:0]  pin_pd_en,
    input logic [PIN_W-1:0]  irq_req,
    input logic [PIN_W-1:0]  data_r,
    input ctl_t              ctl_r,
    input logic              phase_r
);
    logic data_wr, low_wr;
    assign data_wr = bus_we && !bus_aux && (bus_addr == PORT_ADDR);
    assign low_wr  = bus_we &&  bus_aux && (bus_addr == PORT_ADDR) && !phase_r;

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        strap_open_drain |-> ((pin_oe & pin_out) == '0)); // R3

    AST_PULL_ONLY_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        (((pin_pu_en | pin_pd_en) & pin_oe) == '0)); // R6

    AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        ((ctl_r.dir & pin_oe) == '0)); // R5

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (irq_req != '0) |=> ((irq_req & $past(irq_req)) == '0)); // R8

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !data_wr |=> $stable(data_r)); // R5

    AST_LOW_NIBBLE_DEFERRED: assert property (@(posedge clk) disable iff (rst)
        low_wr |=> $stable(ctl_r)); // R7
endmodule

bind pio2_port pio2_port_chk #(.PORT_ADDR(PORT_ADDR)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .bus_we           (bus_we),
    .bus_aux          (bus_aux),
    .bus_addr         (bus_addr),
    .strap_open_drain (strap_open_drain),
    .pin_out          (pin_out),
    .pin_oe           (pin_oe),
    .pin_pu_en        (pin_pu_en),
    .pin_pd_en        (pin_pd_en),
    .irq_req          (irq_req),
    .data_r           (data_r),
    .ctl_r            (ctl_r),
    .phase_r          (phase_r)
);

// File: tb/tb_pio2_port.sv
module tb_pio2_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0, bus_aux = 1'b0;
    logic [3:0] bus_addr = '0, bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic       strap_open_drain = 1'b0, strap_pull_up = 1'b1;
    logic [1:0] pin_in, pin_out, pin_oe, pin_pu_en, pin_pd_en, irq_req, irq_prio;
    logic [1:0] ext_en = 2'b00, ext_val = 2'b00;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // pad model: driver wins, then external source, then weak pull
    for (genvar i = 0; i < 2; i++) begin : g_padm
        assign pin_in[i] = pin_oe[i] ? pin_out[i] :
                           ext_en[i] ? ext_val[i] :
                           pin_pu_en[i] ? 1'b1 : 1'b0;
    end

    pio2_port dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_aux(bus_aux),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .strap_open_drain(strap_open_drain), .strap_pull_up(strap_pull_up),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_pu_en(pin_pu_en), .pin_pd_en(pin_pd_en),
        .irq_req(irq_req), .irq_prio(irq_prio)
    );

    typedef enum int {K_RD, K_OE, K_OUT, K_PU, K_PD, K_IRQ, K_PRIO} kind_e;
    typedef struct {
        int    due;
        kind_e kind;
        logic [3:0] exp;
        string req;
    } item_t;
    item_t sb[$];

    function automatic logic [3:0] observe(kind_e k);
        case (k)
            K_RD:   return bus_rdata;
            K_OE:   return {2'b00, pin_oe};
            K_OUT:  return {2'b00, pin_out};
            K_PU:   return {2'b00, pin_pu_en};
            K_PD:   return {2'b00, pin_pd_en};
            K_IRQ:  return {2'b00, irq_req};
            default: return {2'b00, irq_prio};
        endcase
    endfunction

    // monitor: compare every item in the cycle it is due
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                logic [3:0] act;
                act = observe(sb[i].kind);
                checks++;
                if (act !== sb[i].exp) begin
                    errors++;
                    $display("FAIL %s %s cycle %0d actual %b expected %b",
                             sb[i].req, sb[i].kind.name(), cyc, act, sb[i].exp);
                end
                sb.delete(i);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_at(kind_e k, logic [3:0] v, int d, string r);
        item_t it;
        it.due = cyc + d; it.kind = k; it.exp = v; it.req = r;
        sb.push_back(it);
    endtask

    task automatic chk(kind_e k, logic [3:0] v, string r);
        expect_at(k, v, 1, r);
    endtask

    task automatic bus_write(logic aux, logic [3:0] a, logic [3:0] d);
        tick();
        bus_we = 1'b1; bus_aux = aux; bus_addr = a; bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic set_ctl(logic [7:0] b);
        bus_write(1'b1, 4'h6, b[3:0]);
        bus_write(1'b1, 4'h6, b[7:4]);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // change external pins, expect the irq pulse on the second edge only
    task automatic pin_step(logic [1:0] v, logic [1:0] pulse, string r);
        tick();
        ext_val = v;
        expect_at(K_IRQ, 4'b0000, 1, r);
        expect_at(K_IRQ, {2'b00, pulse}, 2, r);
        expect_at(K_IRQ, 4'b0000, 3, r);
        idle(5);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        // R10 reset state
        chk(K_OE,   4'b0000, "R10");
        chk(K_PU,   4'b0011, "R6");
        chk(K_PD,   4'b0000, "R6");
        chk(K_RD,   4'b0011, "R4");
        chk(K_IRQ,  4'b0000, "R10");
        chk(K_PRIO, 4'b0000, "R10");
        idle(2);

        // R5: data stored while inputs stays off the pins
        bus_write(1'b0, 4'h6, 4'b1110);
        chk(K_OE, 4'b0000, "R5");
        chk(K_RD, 4'b0011, "R5");
        idle(2);

        // R7: low nibble alone has no effect
        bus_write(1'b1, 4'h6, 4'h0);
        chk(K_OE, 4'b0000, "R7");
        idle(2);
        bus_write(1'b1, 4'h6, 4'h0);
        chk(K_OE,  4'b0011, "R2");
        chk(K_OUT, 4'b0010, "R1");
        chk(K_RD,  4'b0010, "R3");
        chk(K_PU,  4'b0000, "R6");
        idle(2);

        // R1: other address ignored
        bus_write(1'b0, 4'h5, 4'b0001);
        chk(K_OUT, 4'b0010, "R1");
        idle(2);
        bus_write(1'b0, 4'h6, 4'b0101);
        chk(K_OUT, 4'b0001, "R2");
        chk(K_RD,  4'b0001, "R4");
        idle(2);

        // R2: pin1 input, pin0 output
        set_ctl(8'h02);
        chk(K_OE,  4'b0001, "R2");
        chk(K_OUT, 4'b0001, "R2");
        chk(K_RD,  4'b0011, "R4");
        chk(K_PU,  4'b0010, "R6");
        idle(2);

        // R5: write while inputs, value appears on return to output
        set_ctl(8'h03);
        bus_write(1'b0, 4'h6, 4'b0010);
        chk(K_OE, 4'b0000, "R5");
        idle(2);
        set_ctl(8'h00);
        chk(K_OUT, 4'b0010, "R5");
        idle(2);

        // R3: open drain
        tick();
        strap_open_drain = 1'b1;
        ext_en = 2'b10; ext_val = 2'b00;
        chk(K_OE,  4'b0001, "R3");
        chk(K_OUT, 4'b0000, "R3");
        chk(K_RD,  4'b0000, "R3");
        tick();
        ext_val = 2'b10;
        chk(K_RD, 4'b0010, "R3");
        tick();
        strap_open_drain = 1'b0;
        ext_en = 2'b00; ext_val = 2'b00;

        // R8/R9: interrupts, pin0 rising, pin1 falling, prio 10
        bus_write(1'b0, 4'h6, 4'b0000);
        tick();
        ext_en = 2'b11;
        idle(4);
        set_ctl(8'h9F);
        chk(K_PRIO, 4'b0010, "R9");
        chk(K_IRQ,  4'b0000, "R8");
        idle(4);
        pin_step(2'b01, 2'b01, "R8");
        pin_step(2'b00, 2'b00, "R8");
        pin_step(2'b10, 2'b00, "R8");
        pin_step(2'b00, 2'b10, "R8");

        // R8: masked
        set_ctl(8'h93);
        idle(4);
        pin_step(2'b11, 2'b00, "R8");
        pin_step(2'b00, 2'b00, "R8");

        // R6: pull-down strap
        tick();
        ext_en = 2'b00;
        strap_pull_up = 1'b0;
        chk(K_PD, 4'b0011, "R6");
        chk(K_PU, 4'b0000, "R6");
        chk(K_RD, 4'b0000, "R4");
        idle(4);

        if (sb.size() != 0) begin
            errors++;
            $display("FAIL scoreboard %0d items left, expected 0", sb.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule